// File: doc/BRIEF.md
# Signed Serial-by-Parallel Multiplier

This block forms the two's complement product of two W-bit signed numbers. One number is held in parallel. The other arrives one bit per clock, least significant bit first. The block is built around a single add/subtract accumulator that is W+1 bits wide. Each clock, its feedback is shifted right by one place through fixed wiring, with the sign bit copied in at the top. The bit that falls out of the accumulator each step moves into a low-order shift register. When the last serial bit has been absorbed, the accumulator and the low register together hold the full 2W-bit product.

The serial operand's top bit carries a negative weight. On that final bit time, the adder therefore becomes a subtractor: the gated parallel operand is inverted and a carry-in of one is applied. On the first bit time of a product, the feedback input is forced to zero. This means no separate clear cycle is needed.

A small state machine runs the block. It has three states:
- ST_IDLE: waiting for work.
- ST_RUN: absorbing serial bits.
- ST_DONE: a single cycle that flags the finished product.

It has five transitions:
- "launch": ST_IDLE to ST_RUN on start.
- "step": ST_RUN to ST_RUN on each valid bit before the last, and while waiting.
- "finish": ST_RUN to ST_DONE on the last valid bit.
- "relaunch": ST_DONE to ST_RUN on start.
- "retire": ST_DONE to ST_IDLE when start is absent.

Top module: `signed_serial_mult`

## Requirements
- R1: When `done` is high, `product` equals the 2W-bit two's complement product of the parallel operand (sampled with start) and the W-bit serial operand, for every pair of signed operands.
- R2: The first valid serial bit has weight 2^0. Bit W-1, the last one absorbed, has weight -2^(W-1), so a negative serial operand yields a correctly signed product.
- R3: `done` is high for exactly one cycle: the cycle that follows the clock edge at which the W-th valid serial bit is absorbed. It is low at every other time.
- R4: A serial bit is absorbed only at an edge where `ser_vld` is high and a product is running. Bits presented with `ser_vld` low are ignored and do not advance the bit count.
- R5: A `start` arriving while a product is running is ignored. The parallel operand is not reloaded, and the running product completes unchanged.
- R6: `product` holds its value from the `done` cycle until the first serial bit of the next product is absorbed.
- R7: After synchronous reset, `done` is 0, `product` is 0 and the block is idle.
- R8: A `start` in the `done` cycle launches a new product at once. The first absorbed bit of the new product discards the old accumulator contents.
- R9: The most negative value times itself yields +2^(2W-2), for example -8 times -8 gives +64 at W=4.
- R10: A serial operand of all zeros yields a product of 0, whatever the parallel operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a product and samples `par_opnd` |
| par_opnd | input | W | Signed parallel operand |
| ser_bit | input | 1 | Current serial operand bit, LSB first |
| ser_vld | input | 1 | Marks `ser_bit` as valid this cycle |
| product | output | 2W | Signed product, `{accumulator, low register}` |
| done | output | 1 | One-cycle strobe for a finished product |

## Verification
The assertions take the following for granted:
- Reset is applied before any product begins.
- `par_opnd` only matters in the cycle where `start` is accepted.
- `ser_vld` may toggle freely, since the controller alone decides when a bit counts.

The stimulus drives every input on the falling edge, away from the sampling edge. It sweeps all operand pairs at W=4. Idle gaps are inserted, carrying deliberately wrong bit values, and stray starts with a different operand are raised mid-run. This exercises the ignore paths while keeping each product to exactly W valid bits.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ssm_state_e;

endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
    import ssm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ser_vld,
    output logic load,
    output logic absorb,
    output logic first,
    output logic last,
    output logic done
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    ssm_state_e       state_q, state_d;
    logic [CW-1:0]    idx_q;
    logic             busy;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)            state_d = ST_RUN;   // launch
            ST_RUN:  if (ser_vld && last)  state_d = ST_DONE;  // finish
            ST_DONE: if (start)            state_d = ST_RUN;   // relaunch
                     else                  state_d = ST_IDLE;  // retire
            default:                       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = 1'b0;
        load   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN:  busy = 1'b1;
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
        absorb = busy && ser_vld;
        first  = (idx_q == '0);
        last   = (idx_q == LAST_IDX);
    end

    // serial bit index
    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (load)   idx_q <= '0;
        else if (absorb) idx_q <= last ? '0 : idx_q + 1'b1;
    end

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_last_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(absorb && last));

    p_idle_bit_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !ser_vld) |=> $stable(idx_q));

    p_start_in_run_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(ser_vld && last)) |=> (state_q == ST_RUN));

endmodule

// File: rtl/ssm_datapath.sv
module ssm_datapath #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           absorb,
    input  logic           first,
    input  logic           last,
    input  logic [W-1:0]   par_in,
    input  logic           ser_bit,
    output logic [2*W-1:0] product
);

    localparam int AW = W + 1;   // accumulator width
    localparam int LW = W - 1;   // low result register width

    logic [W-1:0]  par_q;
    logic [AW-1:0] acc_q;
    logic [LW-1:0] lo_q;
    logic [AW-1:0] feedback, pp, pp_x, sum;
    logic [W-1:0]  lo_shift;

    always_comb begin
        // sign-extended, fixed right shift; gated to zero on the first bit
        feedback = first ? '0 : {acc_q[AW-1], acc_q[AW-1:1]};
        // sign-extended parallel operand, gated by the serial bit
        pp       = ser_bit ? {par_q[W-1], par_q} : '0;
        // negative-weight bit: invert and add one
        pp_x     = pp ^ {AW{last}};
        sum      = feedback + pp_x + {{(AW-1){1'b0}}, last};
        lo_shift = {acc_q[0], lo_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= '0;
            acc_q <= '0;
            lo_q  <= '0;
        end else begin
            if (load) par_q <= par_in;
            if (absorb) begin
                acc_q <= sum;
                if (!first) lo_q <= lo_shift[W-1:1];
            end
        end
    end

    assign product = {acc_q, lo_q};

    p_operand_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (absorb && !first) |-> $stable(par_q));

    p_product_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !absorb |=> $stable(product));

endmodule

// File: rtl/signed_serial_mult.sv
module signed_serial_mult #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   par_opnd,
    input  logic           ser_bit,
    input  logic           ser_vld,
    output logic [2*W-1:0] product,
    output logic           done
);

    logic load, absorb, first, last;

    ssm_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ser_vld (ser_vld),
        .load    (load),
        .absorb  (absorb),
        .first   (first),
        .last    (last),
        .done    (done)
    );

    ssm_datapath #(.W(W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .absorb  (absorb),
        .first   (first),
        .last    (last),
        .par_in  (par_opnd),
        .ser_bit (ser_bit),
        .product (product)
    );

    p_reset_quiet_r7: assert property (@(posedge clk)
        rst |=> (!done && product == '0));

endmodule

// File: tb/signed_serial_mult_test.sv
module signed_serial_mult_test;

    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [W-1:0]  par_opnd;
    logic          ser_bit;
    logic          ser_vld;
    logic [PW-1:0] product;
    logic          done;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;  // 125 MHz

    signed_serial_mult #(.W(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .par_opnd (par_opnd),
        .ser_bit  (ser_bit),
        .ser_vld  (ser_vld),
        .product  (product),
        .done     (done)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a,
                                               input logic [W-1:0] b);
        int ai, bi;
        ai = int'(a) - (a[W-1] ? (1 << W) : 0);
        bi = int'(b) - (b[W-1] ? (1 << W) : 0);
        return PW'(ai * bi);
    endfunction

    // Ends at the falling edge of the done cycle.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit stray, input bit launched);
        logic [PW-1:0] exp;
        exp = ref_mul(a, b);
        if (!launched) begin
            @(negedge clk);
            start = 1'b1; par_opnd = a;
        end
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < W; i++) begin
            if ((int'(a) + int'(b) + i) % 3 == 0) begin
                // R4 gap with a wrong bit; R5 stray start with another operand
                ser_vld = 1'b0; ser_bit = ~b[i];
                if (stray) begin start = 1'b1; par_opnd = ~a; end
                @(negedge clk);
                check(done == 1'b0, "R4 no done in gap", PW'(done), '0);
                start = 1'b0; par_opnd = a;
            end
            ser_vld = 1'b1; ser_bit = b[i];
            @(negedge clk);
            ser_vld = 1'b0;
            if (i < W - 1)
                check(done == 1'b0, "R3 early done", PW'(done), '0);
        end
        check(done == 1'b1, "R3 done strobe", PW'(done), PW'(1));
        if (a == {1'b1, {(W-1){1'b0}}} && b == a)
            check(product == exp, "R9 most negative square", product, exp);
        else if (b == '0)
            check(product == exp, "R10 zero serial operand", product, exp);
        else if (b[W-1])
            check(product == exp, "R2 negative serial weight", product, exp);
        else
            check(product == exp, "R1 product", product, exp);
    endtask

    task automatic hold_check(input logic [PW-1:0] exp);
        @(negedge clk);
        check(done == 1'b0, "R3 single cycle done", PW'(done), '0);
        check(product == exp, "R6 product hold", product, exp);
        ser_vld = 1'b1; ser_bit = 1'b1;  // idle bits must be ignored (R4)
        @(negedge clk);
        @(negedge clk);
        ser_vld = 1'b0;
        check(product == exp && !done, "R4 idle bits ignored", product, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; par_opnd = '0; ser_bit = 1'b0; ser_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R7 reset done", PW'(done), '0);
        check(product == '0, "R7 reset product", product, '0);

        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_op(W'(a), W'(b), ((a + b) % 5 == 0), 1'b0);
                hold_check(ref_mul(W'(a), W'(b)));
            end
        end

        // R8: relaunch in the done cycle, old accumulator discarded
        run_op(W'(3), W'(5), 1'b0, 1'b0);
        start = 1'b1; par_opnd = W'(8);
        run_op(W'(8), W'(8), 1'b0, 1'b1);
        check(product == ref_mul(W'(8), W'(8)), "R8 relaunch from done",
              product, ref_mul(W'(8), W'(8)));
        hold_check(ref_mul(W'(8), W'(8)));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule